// File: doc/BRIEF.md
# 8-bit ALU with four flags

This block is the arithmetic and logic unit of a small accumulator-based processor core. It has no clock and no state. A 4-bit operation code, two data operands and the current carry flag go in. A result byte and four condition flags come out in the same cycle: zero (Z), subtract (N), half-carry (H) and carry (C). The core decides what to do with them.

It covers eight-bit add and subtract, each in a full form and in a form that leaves carry untouched. It also covers the three bitwise operations and eight rotate operations. Four of the rotates serve the short accumulator-only encodings and always report zero as clear. The other four are the general register rotates, which compute zero from their result. Every operation applies its own flag policy.

A packing stage also presents the flags as a flag byte, ready to be stored in the flag register. Decoding instructions, reaching registers or memory, and counting cycles are done elsewhere in the core.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (full add) gives result = (A + B) mod 256. C is the carry out of bit 7 and H is the carry out of bit 3. N = 0 and Z = 1 exactly when the result is 0.
- R2: Op code 1 (add, carry kept) gives the same result, Z, N and H as op code 0, and C equals `carry_in`.
- R3: Op code 2 (full subtract) gives result = (A - B) mod 256 and N = 1. H = 1 when A[3:0] < B[3:0], C = 1 when A < B as unsigned values, and Z = 1 exactly when the result is 0.
- R4: Op code 3 (subtract, carry kept) gives the same result, Z, N and H as op code 2, and C equals `carry_in`.
- R5: Op code 4 (AND) gives A & B with N = 0, H = 1 and C = 0. Z is set from the result.
- R6: Op codes 5 (XOR) and 6 (OR) give A ^ B and A | B with N = H = C = 0. Z is set from the result.
- R7: The circular rotates use operand A. Op codes 7 and 11 rotate left: A[7] goes to both result bit 0 and C. Op codes 8 and 12 rotate right: A[0] goes to both result bit 7 and C.
- R8: The through-carry rotates use operand A. Op codes 9 and 13 rotate left: `carry_in` enters bit 0 and A[7] goes to C. Op codes 10 and 14 rotate right: `carry_in` enters bit 7 and A[0] goes to C.
- R9: The accumulator rotates (op codes 7 to 10) force Z = N = H = 0. The register rotates (op codes 11 to 14) set Z from the result and force N = H = 0.
- R10: `flag_byte` holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3 to 0 are always 0.
- R11: Op code 15 is unassigned and gives result 0 with all four flags 0.
- R12: Operand B has no effect on any rotate (op codes 7 to 14).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 to 15, see requirements) |
| opnd_a | input | 8 | First operand; the only operand used by rotates |
| opnd_b | input | 8 | Second operand for add, subtract and bitwise operations |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Operation result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag |
| flag_c | output | 1 | Carry flag |
| flag_byte | output | 8 | Packed flags, Z/N/H/C in bits 7..4, bits 3..0 zero |

## Verification
There are no registers between the inputs and the outputs, so every result, flag and the packed flag byte is due in the same cycle as its stimulus. The bench changes the inputs just after a falling clock edge and samples all outputs one nanosecond later, well before the next rising edge, so each sample sees only the vector just applied. Sweeps cover every value of A with both carry inputs. For each rotate, two different B values are applied to the same A to show that B has no effect.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD     = 4'd0,
        OP_ADD_KC  = 4'd1,
        OP_SUB     = 4'd2,
        OP_SUB_KC  = 4'd3,
        OP_AND     = 4'd4,
        OP_XOR     = 4'd5,
        OP_OR      = 4'd6,
        OP_ACC_RLC = 4'd7,
        OP_ACC_RRC = 4'd8,
        OP_ACC_RL  = 4'd9,
        OP_ACC_RR  = 4'd10,
        OP_REG_RLC = 4'd11,
        OP_REG_RRC = 4'd12,
        OP_REG_RL  = 4'd13,
        OP_REG_RR  = 4'd14,
        OP_NONE    = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_XOR = 2'd1,
        LG_OR  = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } alu_flags_t;

    localparam int FLAG_COUNT = 4;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] sum,
    output logic              half,
    output logic              carry
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] full_add;
    logic [HALF_W:0] low_add;

    always_comb begin
        full_add = {1'b0, a} + {1'b0, b};
        low_add  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]};
        if (do_sub) begin
            sum   = a - b;
            half  = (a[HALF_W-1:0] < b[HALF_W-1:0]);
            carry = (a < b);
        end else begin
            sum   = full_add[DATA_W-1:0];
            half  = low_add[HALF_W];
            carry = full_add[DATA_W];
        end
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_sel_e        sel,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_XOR:  y = a ^ b;
            LG_OR:   y = a | b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic              cin,
    input  logic              go_left,
    input  logic              thru_carry,
    output logic [DATA_W-1:0] y,
    output logic              cout
);
    logic fill_left;
    logic fill_right;

    always_comb begin
        fill_left  = thru_carry ? cin : a[DATA_W-1];
        fill_right = thru_carry ? cin : a[0];
        if (go_left) begin
            y    = {a[DATA_W-2:0], fill_left};
            cout = a[DATA_W-1];
        end else begin
            y    = {fill_right, a[DATA_W-1:1]};
            cout = a[0];
        end
    end
endmodule

// File: rtl/alu8_flag_pack.sv
module alu8_flag_pack
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_flags_t        flags,
    output logic [DATA_W-1:0] packed_byte
);
    localparam int LOW_W = DATA_W - FLAG_COUNT;

    assign packed_byte[DATA_W-1:LOW_W] = flags;

    genvar gi;
    generate
        for (gi = 0; gi < LOW_W; gi++) begin : g_low_zero
            assign packed_byte[gi] = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_h,
    output logic              flag_c,
    output logic [DATA_W-1:0] flag_byte
);
    alu_op_e           op;
    logic              as_sub;
    logic_sel_e        lg_sel;
    logic              rot_left;
    logic              rot_thru;

    logic [DATA_W-1:0] as_sum;
    logic              as_half;
    logic              as_carry;
    logic [DATA_W-1:0] lg_y;
    logic [DATA_W-1:0] rot_y;
    logic              rot_cout;

    alu_flags_t        fl;
    logic [DATA_W-1:0] res;

    assign op = alu_op_e'(op_sel);

    // operation decode: controls for the three datapath units
    always_comb begin
        as_sub   = 1'b0;
        lg_sel   = LG_AND;
        rot_left = 1'b0;
        rot_thru = 1'b0;
        unique case (op)
            OP_SUB, OP_SUB_KC:       as_sub = 1'b1;
            OP_XOR:                  lg_sel = LG_XOR;
            OP_OR:                   lg_sel = LG_OR;
            OP_ACC_RLC, OP_REG_RLC:  rot_left = 1'b1;
            OP_ACC_RL, OP_REG_RL: begin
                rot_left = 1'b1;
                rot_thru = 1'b1;
            end
            OP_ACC_RR, OP_REG_RR:    rot_thru = 1'b1;
            default: ;
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a      (opnd_a),
        .b      (opnd_b),
        .do_sub (as_sub),
        .sum    (as_sum),
        .half   (as_half),
        .carry  (as_carry)
    );

    alu8_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (lg_sel),
        .y   (lg_y)
    );

    alu8_rotate #(.DATA_W(DATA_W)) u_rotate (
        .a          (opnd_a),
        .cin        (carry_in),
        .go_left    (rot_left),
        .thru_carry (rot_thru),
        .y          (rot_y),
        .cout       (rot_cout)
    );

    // result and per-operation flag policy
    always_comb begin
        res = '0;
        fl  = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res  = as_sum;
                fl.z = (as_sum == '0);
                fl.n = as_sub;
                fl.h = as_half;
                fl.c = as_carry;
            end
            OP_ADD_KC, OP_SUB_KC: begin
                res  = as_sum;
                fl.z = (as_sum == '0);
                fl.n = as_sub;
                fl.h = as_half;
                fl.c = carry_in;
            end
            OP_AND: begin
                res  = lg_y;
                fl.z = (lg_y == '0);
                fl.h = 1'b1;
            end
            OP_XOR, OP_OR: begin
                res  = lg_y;
                fl.z = (lg_y == '0);
            end
            OP_ACC_RLC, OP_ACC_RRC, OP_ACC_RL, OP_ACC_RR: begin
                res  = rot_y;
                fl.c = rot_cout;
            end
            OP_REG_RLC, OP_REG_RRC, OP_REG_RL, OP_REG_RR: begin
                res  = rot_y;
                fl.z = (rot_y == '0);
                fl.c = rot_cout;
            end
            OP_NONE: begin
                res = '0;
                fl  = '0;
            end
            default: begin
                res = '0;
                fl  = '0;
            end
        endcase
    end

    assign result = res;
    assign flag_z = fl.z;
    assign flag_n = fl.n;
    assign flag_h = fl.h;
    assign flag_c = fl.c;

    alu8_flag_pack #(.DATA_W(DATA_W)) u_pack (
        .flags       (fl),
        .packed_byte (flag_byte)
    );
endmodule

// File: rtl/alu8_core_checker.sv
module alu8_core_checker
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic [3:0]        op_sel,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              flag_z,
    input logic              flag_n,
    input logic              flag_h,
    input logic              flag_c,
    input logic [DATA_W-1:0] flag_byte
);
    localparam int LOW_W = DATA_W - FLAG_COUNT;

    always_comb begin
        if (op_sel == OP_SUB || op_sel == OP_SUB_KC)
            p_sub_sets_n_r3: assert (flag_n);
        if (op_sel == OP_ADD_KC || op_sel == OP_SUB_KC)
            p_keep_carry_r2: assert (flag_c == carry_in);
        if (op_sel == OP_AND)
            p_and_flags_r5: assert (flag_h && !flag_c && !flag_n);
        if (op_sel == OP_XOR || op_sel == OP_OR)
            p_xor_or_flags_r6: assert (!flag_h && !flag_c && !flag_n);
        if (op_sel == OP_ACC_RLC || op_sel == OP_REG_RLC)
            p_rlc_wrap_r7: assert (result[0] == opnd_a[DATA_W-1] && flag_c == opnd_a[DATA_W-1]);
        if (op_sel == OP_ACC_RL || op_sel == OP_REG_RL)
            p_rl_thru_r8: assert (result[0] == carry_in && flag_c == opnd_a[DATA_W-1]);
        if (op_sel >= OP_ACC_RLC && op_sel <= OP_ACC_RR)
            p_acc_rot_clear_r9: assert (!flag_z && !flag_n && !flag_h);
        if (op_sel >= OP_REG_RLC && op_sel <= OP_REG_RR)
            p_reg_rot_zero_r9: assert (flag_z == (result == '0) && !flag_n && !flag_h);
        p_flag_byte_r10: assert (flag_byte == {flag_z, flag_n, flag_h, flag_c, {LOW_W{1'b0}}});
        if (op_sel == OP_NONE)
            p_unused_op_r11: assert (result == '0 && !flag_z && !flag_n && !flag_h && !flag_c);
    end
endmodule

bind alu8_core alu8_core_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic       flag_z, flag_n, flag_h, flag_c;
    logic [7:0] flag_byte;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 4 ns period

    alu8_core uut (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .result    (result),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_h    (flag_h),
        .flag_c    (flag_c),
        .flag_byte (flag_byte)
    );

    function automatic string req_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5, 6: return "R6";
            7, 8: return "R7 R9";
            9, 10: return "R8 R9";
            11, 12: return "R7 R9";
            13, 14: return "R8 R9";
            default: return "R11";
        endcase
    endfunction

    // expected {result, z, n, h, c} computed with integer arithmetic
    function automatic logic [11:0] model(input int op, input int a, input int b, input int ci);
        int r, z, n, h, c;
        r = 0; z = 0; n = 0; h = 0; c = 0;
        case (op)
            0, 1: begin
                r = (a + b) % 256;
                h = ((a % 16) + (b % 16) > 15) ? 1 : 0;
                c = (op == 0) ? ((a + b > 255) ? 1 : 0) : ci;
                z = (r == 0) ? 1 : 0;
            end
            2, 3: begin
                r = (a - b + 256) % 256;
                n = 1;
                h = ((a % 16) < (b % 16)) ? 1 : 0;
                c = (op == 2) ? ((a < b) ? 1 : 0) : ci;
                z = (r == 0) ? 1 : 0;
            end
            4: begin r = a & b; h = 1; z = (r == 0) ? 1 : 0; end
            5: begin r = a ^ b; z = (r == 0) ? 1 : 0; end
            6: begin r = a | b; z = (r == 0) ? 1 : 0; end
            7, 11:  begin c = a / 128; r = (a * 2) % 256 + c; end
            8, 12:  begin c = a % 2;   r = a / 2 + c * 128; end
            9, 13:  begin c = a / 128; r = (a * 2) % 256 + ci; end
            10, 14: begin c = a % 2;   r = a / 2 + ci * 128; end
            default: ;
        endcase
        if (op >= 11 && op <= 14) z = (r == 0) ? 1 : 0;  // register rotates, R9
        return {r[7:0], z[0], n[0], h[0], c[0]};
    endfunction

    task automatic apply_and_check(input int op, input int a, input int b, input int ci, input string extra);
        logic [11:0] exp_v;
        logic [11:0] got_v;
        logic [7:0]  exp_fb;
        @(negedge clk);
        op_sel   = op[3:0];
        opnd_a   = a[7:0];
        opnd_b   = b[7:0];
        carry_in = ci[0];
        #1;
        exp_v  = model(op, a, b, ci);
        got_v  = {result, flag_z, flag_n, flag_h, flag_c};
        exp_fb = {exp_v[3:0], 4'b0000};
        checks++;
        if (got_v !== exp_v) begin
            failures++;
            $display("FAIL %s%s op=%0d a=%02h b=%02h ci=%0d: got res=%02h znhc=%04b expected res=%02h znhc=%04b",
                     req_of(op), extra, op, a, b, ci, got_v[11:4], got_v[3:0], exp_v[11:4], exp_v[3:0]);
        end
        checks++;
        if (flag_byte !== exp_fb) begin
            failures++;
            $display("FAIL R10 op=%0d a=%02h b=%02h ci=%0d: got flag_byte=%02h expected %02h",
                     op, a, b, ci, flag_byte, exp_fb);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // initial state: add of zeros gives zero result with Z set (R1)
        apply_and_check(0, 0, 0, 0, "");
        // boundary corners for R1..R4: half-carry and carry edges
        apply_and_check(0, 8'h0F, 8'h01, 0, "");
        apply_and_check(0, 8'hFF, 8'h01, 0, "");
        apply_and_check(1, 8'hFF, 8'h01, 1, "");
        apply_and_check(2, 8'h10, 8'h01, 0, "");
        apply_and_check(2, 8'h00, 8'h01, 0, "");
        apply_and_check(3, 8'h00, 8'h01, 0, "");
        // sweep of add, subtract and bitwise: every A, 16 spread B, both carries
        for (int op = 0; op <= 6; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++)
                    for (int ci = 0; ci < 2; ci++)
                        apply_and_check(op, a, (bi * 17 + a / 16) % 256, ci, "");
        // rotates: every A, both carries, two B values for R12
        for (int op = 7; op <= 14; op++)
            for (int a = 0; a < 256; a++)
                for (int ci = 0; ci < 2; ci++) begin
                    apply_and_check(op, a, 8'h00, ci, "");
                    apply_and_check(op, a, a ^ 8'hA5, ci, " R12");
                end
        // unused code R11
        for (int a = 0; a < 256; a++)
            apply_and_check(15, a, 255 - a, a % 2, "");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule